// File: doc/BRIEF.md
# Register-Cached Evaluation Stack

This block is a hardware stack for expression evaluation. A client pushes operands and applies pop or binary arithmetic commands. The binary commands are add, subtract, multiply and divide. Each binary command implicitly consumes the two topmost entries and leaves one result in their place. Reverse-Polish expressions can therefore be evaluated directly, one token per command.

Only the uppermost `REG_N` entries live in flip-flops. Entries below that window go to a spill area in an external synchronous memory. Memory is touched only at two points. The first is when a push arrives while the register window is full: the deepest cached entry is written out. The second is when a command needs more cached entries than the window holds: the most recently spilled entry is read back. While such an access runs, the command port withholds `cmd_ready`.

Commands use a valid/ready handshake. The top entry is always visible on `tos_data`. Error pulses report underflow, overflow of the spill area and division by zero.

Top module: `evstack_unit`

## Requirements
- R1: After reset the stack is empty. `depth` is 0, `tos_valid` is 0, `cmd_ready` is 1, `mem_req` is 0 and all three error outputs are 0.
- R2: Command codes on `cmd_op` are 0 push, 1 pop, 2 add, 3 subtract, 4 multiply and 5 divide. Push places `cmd_imm` on top and pop removes the top. The stack is last-in first-out across any depth up to its capacity. `tos_data` shows the top entry, `depth` shows the entry count, and `tos_valid` is high exactly when `depth` is nonzero.
- R3: For codes 2 to 5, call the entry below the top X and the top entry Y. The command removes both and pushes X+Y, X-Y, the low 32 bits of X*Y, or X/Y, in that order of codes. Division is signed and truncates toward zero. Dividing the most negative value by -1 yields the most negative value.
- R4: Division by zero yields all ones and pulses `err_div0` for one cycle.
- R5: A pop on an empty stack, or a binary command with fewer than two entries in total, pulses `err_underflow`. It leaves depth, contents and memory untouched.
- R6: A push while `REG_N` entries are cached writes the deepest cached entry to spill address k, where k is the number of entries already spilled. It then completes the push. No other command writes memory.
- R7: A binary command with fewer than two cached entries, or a pop with one cached entry and spilled entries present, first reads back spill address k-1, the most recently spilled entry. Reads repeat until two entries are cached or the spill area is empty. No other command reads memory.
- R8: `cmd_ready` is low in every cycle in which `mem_req` is high.
- R9: A push when `depth` equals `REG_N + 2**MEM_AW` pulses `err_overflow` and changes nothing.
- R10: Codes 6 and 7 are accepted but change nothing. They raise no error and cause no memory access.
- R11: With `REG_N` = 2, the expression a b c * + a d c * + e - / evaluates correctly using exactly three spill writes and three refill reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted when high with cmd_valid |
| cmd_op | input | 3 | Command code |
| cmd_imm | input | DATA_W | Value for push |
| tos_data | output | DATA_W | Top entry |
| tos_valid | output | 1 | Stack non-empty |
| depth | output | $clog2(REG_N+2**MEM_AW+1) | Total entry count |
| err_underflow | output | 1 | One-cycle pulse: too few entries |
| err_overflow | output | 1 | One-cycle pulse: stack at capacity |
| err_div0 | output | 1 | One-cycle pulse: division by zero |
| mem_req | output | 1 | Spill memory access |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | MEM_AW | Spill address |
| mem_wdata | output | DATA_W | Spill write data |
| mem_rdata | input | DATA_W | Read data, valid the cycle after a read request |

## Verification
The bench builds the unit with `REG_N` = 2 and `MEM_AW` = 2, giving a capacity of six entries. Most pushes past the second entry then spill, and most binary commands at depth three or more refill. This brings several scenarios within a short run:
- spill and refill ordering;
- the exact memory traffic of the reference expression;
- full-capacity overflow.

An 8-by-8 operand grid for each arithmetic code covers wrap-around, signed-division corners and the zero divisor. Chained subtractions from every starting depth cover refills inside binary commands.

// File: rtl/evstack_pkg.sv
package evstack_pkg;

    typedef enum logic [2:0] {
        OP_PUSH = 3'd0,
        OP_POP  = 3'd1,
        OP_ADD  = 3'd2,
        OP_SUB  = 3'd3,
        OP_MUL  = 3'd4,
        OP_DIV  = 3'd5,
        OP_RSV6 = 3'd6,
        OP_RSV7 = 3'd7
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SPILL = 3'd1,
        ST_RD    = 3'd2,
        ST_RDW   = 3'd3,
        ST_EXEC  = 3'd4
    } ust_e;

endpackage

// File: rtl/evstack_alu.sv
module evstack_alu
    import evstack_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  op_e               op,
    input  logic [DATA_W-1:0] lhs,
    input  logic [DATA_W-1:0] rhs,
    output logic [DATA_W-1:0] res,
    output logic              div0
);
    localparam logic [DATA_W-1:0] ALL_ONES = '1;

    always_comb begin
        res  = '0;
        div0 = 1'b0;
        case (op)
            OP_ADD: res = lhs + rhs;
            OP_SUB: res = lhs - rhs;
            OP_MUL: res = lhs * rhs;
            OP_DIV: begin
                if (rhs == '0) begin
                    res  = ALL_ONES;
                    div0 = 1'b1;
                end else if (rhs == ALL_ONES) begin
                    // divisor -1: negate, wrapping for the most negative value
                    res = '0 - lhs;
                end else begin
                    res = $signed(lhs) / $signed(rhs);
                end
            end
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/evstack_plan.sv
module evstack_plan
    import evstack_pkg::*;
#(
    parameter int REG_N   = 4,
    parameter int CAP     = 20,
    parameter int RC_W    = 3,
    parameter int MC_W    = 5,
    parameter int DEPTH_W = 5
) (
    input  op_e                op,
    input  logic [RC_W-1:0]    rc,
    input  logic [MC_W-1:0]    mc,
    input  logic [DEPTH_W-1:0] depth,
    output logic               need_spill,
    output logic               need_refill,
    output logic               underflow,
    output logic               overflow
);
    logic few_cached;
    assign few_cached = (int'(rc) < 2);

    always_comb begin
        need_spill  = 1'b0;
        need_refill = 1'b0;
        underflow   = 1'b0;
        overflow    = 1'b0;
        case (op)
            OP_PUSH: begin
                overflow   = (int'(depth) == CAP);
                need_spill = !overflow && (int'(rc) == REG_N);
            end
            OP_POP: begin
                underflow   = (depth == '0);
                need_refill = !underflow && few_cached && (mc != '0);
            end
            OP_ADD, OP_SUB, OP_MUL, OP_DIV: begin
                underflow   = (int'(depth) < 2);
                need_refill = !underflow && few_cached;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/evstack_unit.sv
module evstack_unit
    import evstack_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int REG_N   = 4,
    parameter int MEM_AW  = 4,
    localparam int CAP     = REG_N + (1 << MEM_AW),
    localparam int DEPTH_W = $clog2(CAP + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    output logic               cmd_ready,
    input  logic [2:0]         cmd_op,
    input  logic [DATA_W-1:0]  cmd_imm,
    output logic [DATA_W-1:0]  tos_data,
    output logic               tos_valid,
    output logic [DEPTH_W-1:0] depth,
    output logic               err_underflow,
    output logic               err_overflow,
    output logic               err_div0,
    output logic               mem_req,
    output logic               mem_we,
    output logic [MEM_AW-1:0]  mem_addr,
    output logic [DATA_W-1:0]  mem_wdata,
    input  logic [DATA_W-1:0]  mem_rdata
);
    localparam int RC_W = $clog2(REG_N + 1);
    localparam int MC_W = MEM_AW + 1;

    typedef struct packed {
        ust_e                           st;
        logic [REG_N-1:0][DATA_W-1:0]   win;
        logic [RC_W-1:0]                rc;
        logic [MC_W-1:0]                mc;
        op_e                            pop;
        logic [DATA_W-1:0]              pimm;
        logic                           e_uf;
        logic                           e_of;
        logic                           e_dz;
    } regs_t;

    regs_t q, d;

    op_e               op_sel;
    logic [DATA_W-1:0] imm_sel;
    logic [DATA_W-1:0] alu_res;
    logic              alu_dz;
    logic              p_spill, p_refill, p_uf, p_of;
    logic              do_exec;
    logic [MC_W-1:0]   mc_dec;

    assign op_sel  = (q.st == ST_EXEC) ? q.pop  : op_e'(cmd_op);
    assign imm_sel = (q.st == ST_EXEC) ? q.pimm : cmd_imm;
    assign mc_dec  = q.mc - 1'b1;

    evstack_alu #(.DATA_W(DATA_W)) alu_i (
        .op   (op_sel),
        .lhs  (q.win[1]),
        .rhs  (q.win[0]),
        .res  (alu_res),
        .div0 (alu_dz)
    );

    evstack_plan #(
        .REG_N(REG_N), .CAP(CAP), .RC_W(RC_W), .MC_W(MC_W), .DEPTH_W(DEPTH_W)
    ) plan_i (
        .op          (op_e'(cmd_op)),
        .rc          (q.rc),
        .mc          (q.mc),
        .depth       (depth),
        .need_spill  (p_spill),
        .need_refill (p_refill),
        .underflow   (p_uf),
        .overflow    (p_of)
    );

    // next-state logic
    always_comb begin
        d       = q;
        d.e_uf  = 1'b0;
        d.e_of  = 1'b0;
        d.e_dz  = 1'b0;
        do_exec = 1'b0;

        case (q.st)
            ST_IDLE: begin
                if (cmd_valid) begin
                    if (p_uf) begin
                        d.e_uf = 1'b1;
                    end else if (p_of) begin
                        d.e_of = 1'b1;
                    end else if (p_spill || p_refill) begin
                        d.pop  = op_e'(cmd_op);
                        d.pimm = cmd_imm;
                        d.st   = p_spill ? ST_SPILL : ST_RD;
                    end else begin
                        do_exec = 1'b1;
                    end
                end
            end
            ST_SPILL: begin
                d.rc = q.rc - 1'b1;
                d.mc = q.mc + 1'b1;
                d.st = ST_EXEC;
            end
            ST_RD: begin
                d.st = ST_RDW;
            end
            ST_RDW: begin
                for (int i = 0; i < REG_N; i++) begin
                    if (RC_W'(i) == q.rc) d.win[i] = mem_rdata;
                end
                d.rc = q.rc + 1'b1;
                d.mc = mc_dec;
                d.st = ((int'(q.rc) + 1 < 2) && (q.mc > MC_W'(1))) ? ST_RD : ST_EXEC;
            end
            ST_EXEC: begin
                do_exec = 1'b1;
                d.st    = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase

        if (do_exec) begin
            case (op_sel)
                OP_PUSH: begin
                    for (int i = REG_N - 1; i > 0; i--) d.win[i] = q.win[i-1];
                    d.win[0] = imm_sel;
                    d.rc     = q.rc + 1'b1;
                end
                OP_POP: begin
                    for (int i = 0; i < REG_N - 1; i++) d.win[i] = q.win[i+1];
                    d.win[REG_N-1] = '0;
                    d.rc           = q.rc - 1'b1;
                end
                OP_ADD, OP_SUB, OP_MUL, OP_DIV: begin
                    d.win[0] = alu_res;
                    for (int i = 1; i < REG_N - 1; i++) d.win[i] = q.win[i+1];
                    d.win[REG_N-1] = '0;
                    d.rc           = q.rc - 1'b1;
                    d.e_dz         = alu_dz;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cmd_ready     = (q.st == ST_IDLE);
    assign tos_data      = q.win[0];
    assign depth         = DEPTH_W'(q.rc) + DEPTH_W'(q.mc);
    assign tos_valid     = (depth != '0);
    assign err_underflow = q.e_uf;
    assign err_overflow  = q.e_of;
    assign err_div0      = q.e_dz;
    assign mem_req       = (q.st == ST_SPILL) || (q.st == ST_RD);
    assign mem_we        = (q.st == ST_SPILL);
    assign mem_addr      = (q.st == ST_SPILL) ? q.mc[MEM_AW-1:0] : mc_dec[MEM_AW-1:0];
    assign mem_wdata     = q.win[REG_N-1];
endmodule

// File: rtl/evstack_unit_chk.sv
module evstack_unit_chk #(
    parameter int DATA_W  = 32,
    parameter int REG_N   = 4,
    parameter int MEM_AW  = 4,
    parameter int DEPTH_W = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cmd_ready,
    input logic [DATA_W-1:0]  tos_data,
    input logic               tos_valid,
    input logic [DEPTH_W-1:0] depth,
    input logic               err_underflow,
    input logic               err_overflow,
    input logic               err_div0,
    input logic               mem_req,
    input logic               mem_we
);
    localparam int CAP = REG_N + (1 << MEM_AW);

    a_r8_no_accept_during_mem: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !cmd_ready);

    a_r6_write_only_when_window_full: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (int'(depth) >= REG_N));

    a_r2_tos_valid_tracks_depth: assert property (@(posedge clk) disable iff (!rst_n)
        tos_valid == (depth != '0));

    a_r5_underflow_keeps_depth: assert property (@(posedge clk) disable iff (!rst_n)
        err_underflow |-> (depth == $past(depth)));

    a_r9_overflow_at_capacity: assert property (@(posedge clk) disable iff (!rst_n)
        err_overflow |-> (int'(depth) == CAP));

    a_r4_div0_gives_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
        err_div0 |-> (tos_data == {DATA_W{1'b1}}));

    a_r2_depth_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        int'(depth) <= CAP);
endmodule

bind evstack_unit evstack_unit_chk #(
    .DATA_W(DATA_W), .REG_N(REG_N), .MEM_AW(MEM_AW), .DEPTH_W(DEPTH_W)
) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_ready     (cmd_ready),
    .tos_data      (tos_data),
    .tos_valid     (tos_valid),
    .depth         (depth),
    .err_underflow (err_underflow),
    .err_overflow  (err_overflow),
    .err_div0      (err_div0),
    .mem_req       (mem_req),
    .mem_we        (mem_we)
);

// File: tb/evstack_unit_tb_top.sv
module evstack_unit_tb_top;
    localparam int DW  = 32;
    localparam int N   = 2;
    localparam int AW  = 2;
    localparam int CAP = N + (1 << AW);
    localparam int DEPTH_W = $clog2(CAP + 1);

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               cmd_valid = 1'b0;
    logic               cmd_ready;
    logic [2:0]         cmd_op = '0;
    logic [DW-1:0]      cmd_imm = '0;
    logic [DW-1:0]      tos_data;
    logic               tos_valid;
    logic [DEPTH_W-1:0] depth;
    logic               err_underflow, err_overflow, err_div0;
    logic               mem_req, mem_we;
    logic [AW-1:0]      mem_addr;
    logic [DW-1:0]      mem_wdata;
    logic [DW-1:0]      mem_rdata = '0;

    always #2.5 clk = ~clk;

    evstack_unit #(.DATA_W(DW), .REG_N(N), .MEM_AW(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_imm(cmd_imm), .tos_data(tos_data), .tos_valid(tos_valid),
        .depth(depth), .err_underflow(err_underflow), .err_overflow(err_overflow),
        .err_div0(err_div0), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // spill memory model
    logic [DW-1:0] mem_m [0:(1<<AW)-1];
    int wr_cnt = 0;
    int rd_cnt = 0;
    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) begin
                mem_m[mem_addr] <= mem_wdata;
                wr_cnt <= wr_cnt + 1;
            end else begin
                mem_rdata <= mem_m[mem_addr];
                rd_cnt <= rd_cnt + 1;
            end
        end
    end

    int busy_ready_bad = 0;
    int busy_seen = 0;
    always @(negedge clk) begin
        if (rst_n && mem_req) begin
            if (cmd_ready) busy_ready_bad++;
            else           busy_seen++;
        end
    end

    int n_chk = 0;
    int n_fail = 0;
    logic f_uf, f_of, f_dz;

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_cmd(input logic [2:0] op, input logic [DW-1:0] imm);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_imm   = imm;
        while (!cmd_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        f_uf = err_underflow;
        f_of = err_overflow;
        f_dz = err_div0;
        while (!cmd_ready) begin
            @(negedge clk);
            f_uf = f_uf | err_underflow;
            f_of = f_of | err_overflow;
            f_dz = f_dz | err_div0;
        end
    endtask

    function automatic logic [DW-1:0] expect_op(input int op, input logic [DW-1:0] x, input logic [DW-1:0] y);
        case (op)
            2: return x + y;
            3: return x - y;
            4: return x * y;
            default: begin
                if (y == 0) return '1;
                if (y == '1) return 32'd0 - x;
                return $signed(x) / $signed(y);
            end
        endcase
    endfunction

    logic [DW-1:0] grid [0:7];
    logic [DW-1:0] model [0:7];

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        int w0, r0;
        grid[0] = 32'd0;        grid[1] = 32'd1;
        grid[2] = 32'hFFFFFFFF; grid[3] = 32'd7;
        grid[4] = 32'hFFFFFFF8; grid[5] = 32'h7FFFFFFF;
        grid[6] = 32'h80000000; grid[7] = 32'd3;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 ready", 32'(cmd_ready), 32'd1);
        check("R1 depth", 32'(depth), 32'd0);
        check("R1 tos_valid", 32'(tos_valid), 32'd0);
        check("R1 mem_req", 32'(mem_req), 32'd0);
        check("R1 errors", {29'd0, err_underflow, err_overflow, err_div0}, 32'd0);

        // R10 reserved codes
        w0 = wr_cnt; r0 = rd_cnt;
        do_cmd(3'd6, 32'h55);
        check("R10 code6 depth", 32'(depth), 32'd0);
        check("R10 code6 flags", {29'd0, f_uf, f_of, f_dz}, 32'd0);
        do_cmd(3'd0, 32'h1234);
        do_cmd(3'd7, 32'h99);
        check("R10 code7 tos", tos_data, 32'h1234);
        check("R10 code7 depth", 32'(depth), 32'd1);
        check("R10 code7 flags", {29'd0, f_uf, f_of, f_dz}, 32'd0);
        check("R10 no mem", 32'(wr_cnt - w0 + rd_cnt - r0), 32'd0);

        // R5 underflow
        do_cmd(3'd2, 32'd0);
        check("R5 add with one entry flag", 32'(f_uf), 32'd1);
        check("R5 add with one entry depth", 32'(depth), 32'd1);
        check("R5 add with one entry tos", tos_data, 32'h1234);
        do_cmd(3'd1, 32'd0);
        check("R2 pop to empty", 32'(depth), 32'd0);
        check("R2 tos_valid empty", 32'(tos_valid), 32'd0);
        do_cmd(3'd1, 32'd0);
        check("R5 pop empty flag", 32'(f_uf), 32'd1);
        check("R5 pop empty depth", 32'(depth), 32'd0);
        do_cmd(3'd5, 32'd0);
        check("R5 div empty flag", 32'(f_uf), 32'd1);

        // R3 / R4 operand grid sweep
        w0 = wr_cnt; r0 = rd_cnt;
        for (int op = 2; op <= 5; op++) begin
            for (int i = 0; i < 8; i++) begin
                for (int j = 0; j < 8; j++) begin
                    do_cmd(3'd0, grid[i]);
                    do_cmd(3'd0, grid[j]);
                    do_cmd(3'(op), 32'd0);
                    check($sformatf("R3 op%0d %h,%h", op, grid[i], grid[j]), tos_data,
                          expect_op(op, grid[i], grid[j]));
                    check("R4 div0 flag", 32'(f_dz), 32'((op == 5) && (grid[j] == 0)));
                    check("R3 depth after op", 32'(depth), 32'd1);
                    do_cmd(3'd1, 32'd0);
                end
            end
        end
        check("R6 R7 no traffic within window", 32'(wr_cnt - w0 + rd_cnt - r0), 32'd0);

        // R6 fill to capacity, R9 overflow, R7 drain in LIFO order
        w0 = wr_cnt; r0 = rd_cnt;
        for (int k = 0; k < CAP; k++) begin
            do_cmd(3'd0, 32'(100 + k));
            check("R2 push tos", tos_data, 32'(100 + k));
            check("R2 push depth", 32'(depth), 32'(k + 1));
            check("R6 spill count", 32'(wr_cnt - w0), 32'((k + 1 > N) ? (k + 1 - N) : 0));
        end
        for (int j = 0; j < CAP - N; j++) begin
            check("R6 spill address order", mem_m[j], 32'(100 + j));
        end
        do_cmd(3'd0, 32'd777);
        check("R9 overflow flag", 32'(f_of), 32'd1);
        check("R9 depth kept", 32'(depth), 32'(CAP));
        check("R9 tos kept", tos_data, 32'(100 + CAP - 1));
        check("R9 no spill", 32'(wr_cnt - w0), 32'(CAP - N));
        for (int k = CAP - 1; k >= 0; k--) begin
            check("R2 LIFO tos", tos_data, 32'(100 + k));
            do_cmd(3'd1, 32'd0);
            check("R2 pop depth", 32'(depth), 32'(k));
        end
        check("R7 refill count on drain", 32'(rd_cnt - r0), 32'(CAP - N));
        check("R7 no extra writes", 32'(wr_cnt - w0), 32'(CAP - N));

        // R7 chained subtractions from every starting depth
        for (int dd = 2; dd <= CAP; dd++) begin
            int cnt;
            cnt = 0;
            for (int k = 0; k < dd; k++) begin
                model[k] = 32'(k * 37 + 5);
                do_cmd(3'd0, model[k]);
                cnt++;
            end
            while (cnt > 1) begin
                model[cnt-2] = model[cnt-2] - model[cnt-1];
                cnt--;
                do_cmd(3'd3, 32'd0);
                check($sformatf("R7 chain depth%0d tos", dd), tos_data, model[cnt-1]);
                check("R7 chain depth", 32'(depth), 32'(cnt));
            end
            do_cmd(3'd1, 32'd0);
            check("R7 chain empty", 32'(depth), 32'd0);
        end

        // R11 reference expression: (a + b*c) / (a + d*c - e)
        w0 = wr_cnt; r0 = rd_cnt;
        do_cmd(3'd0, 32'd20); do_cmd(3'd0, 32'd3); do_cmd(3'd0, 32'd4);
        do_cmd(3'd4, 32'd0);  do_cmd(3'd2, 32'd0);
        do_cmd(3'd0, 32'd20); do_cmd(3'd0, 32'd2); do_cmd(3'd0, 32'd4);
        do_cmd(3'd4, 32'd0);  do_cmd(3'd2, 32'd0);
        do_cmd(3'd0, 32'd12); do_cmd(3'd3, 32'd0); do_cmd(3'd5, 32'd0);
        check("R11 result", tos_data, 32'd2);
        check("R11 depth", 32'(depth), 32'd1);
        check("R11 spill writes", 32'(wr_cnt - w0), 32'd3);
        check("R11 refill reads", 32'(rd_cnt - r0), 32'd3);
        do_cmd(3'd1, 32'd0);

        // R8 handshake held off during memory access
        check("R8 ready high during access", 32'(busy_ready_bad), 32'd0);
        check("R8 accesses observed", 32'(busy_seen > 0), 32'd1);

        finish_run();
    end
endmodule